// File: doc/BRIEF.md
# Fast-to-Slow Bus Acknowledge Conditioner

This block sits between a fast CPU with an asynchronous, active-low address strobe and a slow peripheral bus clocked by the slow bus clock. It brings the CPU strobe into the slow domain through two flops and presents that copy to the legacy chipset decoder. It then decides when the CPU may see a data acknowledge. A legacy chipset acknowledge that lingers after its cycle has ended must never complete a later CPU cycle. To prevent that, an acknowledge is taken only once per access, and only after the legacy acknowledge has been seen released for a configurable guard gap. The I/O window gets an extra delay and a longer gap.

For the sound-chip window the block drives the chip select itself and keeps the strobe away from the legacy decoder. It then produces its own acknowledge a fixed number of slow clocks after the select. ROM accesses are also hidden from the legacy decoder and are acknowledged locally after a fixed delay. The CPU acknowledge is released asynchronously as soon as the CPU strobe goes inactive.

Top module: `bus_ack_conditioner`

## Requirements
- R1: After reset, `cpu_dtack_n`, `snd_cs_n` and `legacy_as_n` are all high (inactive).
- R2: For an address outside the ROM and sound windows, `legacy_as_n` falls on the second rising clock edge after `cpu_as_n` falls (two-flop synchroniser).
- R3: `cpu_dtack_n` goes high as soon as `cpu_as_n` goes high, with no clock edge needed, and is never low while `cpu_as_n` is high.
- R4: For plain and I/O addresses, the CPU acknowledge comes only from a legacy acknowledge produced during the current access. With the legacy acknowledge arriving L edges after `legacy_as_n` falls, `cpu_dtack_n` falls 3+L edges after `cpu_as_n` falls for a plain address.
- R5: Once a legacy acknowledge has been used, no further legacy acknowledge is accepted until `legacy_dtack_n` has been high on GUARD_STD (default 1) rising edges in a row. After an I/O access the count is GUARD_IO (default 3).
- R6: I/O window accesses (default 0xFF8000–0xFFFFFF, sound window excluded) are acknowledged no earlier than 5 edges after `cpu_as_n` falls: latency max(3+L, 5) by default.
- R7: For the sound window (default 0xFF8800–0xFF88FF), `snd_cs_n` is low while the synchronised strobe is active and `legacy_as_n` stays high.
- R8: The sound acknowledge falls 2 rising edges after `snd_cs_n` falls, and is removed when the access ends.
- R9: For the ROM window (default 0xFC0000–0xFEFFFF), `legacy_as_n` stays high and `cpu_dtack_n` falls 5 edges after `cpu_as_n` falls.
- R10: Back-to-back sound writes, with the CPU strobe high across a single clock edge between them, each receive a fresh select pulse and the full 2-edge acknowledge delay.
- R11: Window priority is ROM, then sound, then I/O. Every other address is a plain access with the minimum gap and no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_as_n | input | 1 | CPU address strobe, asynchronous, active low |
| cpu_addr | input | AW | CPU address, stable while the strobe is low |
| legacy_dtack_n | input | 1 | Acknowledge from the legacy chipset, active low |
| legacy_as_n | output | 1 | Synchronised strobe to the legacy decoder, held high for ROM and sound |
| snd_cs_n | output | 1 | Locally decoded sound-chip select, active low |
| cpu_dtack_n | output | 1 | Conditioned acknowledge to the CPU, active low |

## Verification
On every cycle, the assertions check that the CPU acknowledge never lies outside a CPU strobe, and that the sound select and the legacy strobe are never active together. They also check that a sound acknowledge follows at least two edges of select, that a legacy-path acknowledge was preceded by a legacy strobe and legacy acknowledge, and that reset leaves everything inactive. Only the bench scenarios can show exact latencies per window, and that a stale legacy acknowledge lingering across back-to-back cycles is ignored. The bench's chipset model marks whether its acknowledge was produced for the current strobe. They also show that each of four consecutive sound writes gets its own full timed cycle.

// File: rtl/bus_ack_pkg.sv
package bus_ack_pkg;

  typedef enum logic [1:0] {RG_PLAIN, RG_IO, RG_SND, RG_ROM} region_e;

  // Window priority: ROM, sound, I/O, plain.
  function automatic region_e classify(input logic [31:0] a,
                                       input logic [31:0] rom_lo, input logic [31:0] rom_hi,
                                       input logic [31:0] snd_lo, input logic [31:0] snd_hi,
                                       input logic [31:0] io_lo,  input logic [31:0] io_hi);
    if (a >= rom_lo && a <= rom_hi)      return RG_ROM;
    else if (a >= snd_lo && a <= snd_hi) return RG_SND;
    else if (a >= io_lo && a <= io_hi)   return RG_IO;
    else                                 return RG_PLAIN;
  endfunction

  // Edges from synchronised strobe to acknowledge edge requested per window.
  function automatic int need_of(input region_e r, input int d_plain, input int d_io,
                                 input int d_snd, input int d_rom);
    case (r)
      RG_IO:   return d_io;
      RG_SND:  return d_snd;
      RG_ROM:  return d_rom;
      default: return d_plain;
    endcase
  endfunction

  // Delay satisfied once the strobe has been low on cnt edges.
  function automatic logic dly_ready(input int cnt, input int need);
    return (cnt + 1) >= need;
  endfunction

  // Guard gap in edges, clamped to 1..3.
  function automatic logic [1:0] gap_of(input region_e r, input int g_plain, input int g_io);
    int g;
    g = (r == RG_IO) ? g_io : g_plain;
    if (g < 1) g = 1;
    if (g > 3) g = 3;
    return 2'(g);
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/ack_as_sync.sv
module ack_as_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], async_n};
  end

  assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/ack_range_decode.sv
module ack_range_decode
  import bus_ack_pkg::*;
#(
  parameter int AW = 24,
  parameter logic [AW-1:0] ROM_LO = 24'hFC0000,
  parameter logic [AW-1:0] ROM_HI = 24'hFEFFFF,
  parameter logic [AW-1:0] SND_LO = 24'hFF8800,
  parameter logic [AW-1:0] SND_HI = 24'hFF88FF,
  parameter logic [AW-1:0] IO_LO  = 24'hFF8000,
  parameter logic [AW-1:0] IO_HI  = 24'hFFFFFF
) (
  input  logic [AW-1:0] addr,
  output region_e       region
);
  assign region = classify(32'(addr), 32'(ROM_LO), 32'(ROM_HI), 32'(SND_LO),
                           32'(SND_HI), 32'(IO_LO), 32'(IO_HI));
endmodule

// File: rtl/ack_sequencer.sv
module ack_sequencer
  import bus_ack_pkg::*;
#(
  parameter int DLY_PLAIN = 0,
  parameter int DLY_IO    = 3,
  parameter int DLY_SND   = 2,
  parameter int DLY_ROM   = 3,
  parameter int GUARD_STD = 1,
  parameter int GUARD_IO  = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cpu_as_n,
  input  logic    slow_as_n,
  input  region_e region,
  input  logic    legacy_dtack_n,
  output logic    ack_q_n,
  output logic    acc_legacy,
  output logic    acc_local
);
  localparam int MAXN = max4(DLY_PLAIN, DLY_IO, DLY_SND, DLY_ROM);
  localparam int CW   = $clog2(MAXN + 1) + 1;

  logic [CW-1:0] dly_cnt;
  logic [1:0]    hi_cnt;
  logic [1:0]    gap_req;
  logic          consumed;
  logic          done;
  logic          is_legacy, dly_ok, live;

  assign is_legacy  = (region == RG_PLAIN) || (region == RG_IO);
  assign dly_ok     = dly_ready(int'(dly_cnt), need_of(region, DLY_PLAIN, DLY_IO, DLY_SND, DLY_ROM));
  assign live       = !slow_as_n && !done;
  assign acc_legacy = live && is_legacy && dly_ok && !consumed && !legacy_dtack_n;
  assign acc_local  = live && !is_legacy && dly_ok;

  // Edges since the synchronised strobe went active, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 dly_cnt <= '0;
    else if (slow_as_n)         dly_cnt <= '0;
    else if (dly_cnt != '1)     dly_cnt <= dly_cnt + 1'b1;
  end

  // Run of edges with the legacy acknowledge released, saturating at 3.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hi_cnt <= 2'd3;
    else if (!legacy_dtack_n) hi_cnt <= '0;
    else if (hi_cnt != 2'd3)  hi_cnt <= hi_cnt + 2'd1;
  end

  // A used legacy acknowledge stays locked out until released for the gap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      consumed <= 1'b0;
      gap_req  <= 2'd1;
    end else if (acc_legacy) begin
      consumed <= 1'b1;
      gap_req  <= gap_of(region, GUARD_STD, GUARD_IO);
    end else if (hi_cnt >= gap_req) begin
      consumed <= 1'b0;
    end
  end

  // One acknowledge per access of the synchronised strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        done <= 1'b0;
    else if (slow_as_n)                done <= 1'b0;
    else if (acc_legacy || acc_local)  done <= 1'b1;
  end

  // Acknowledge register, preset at once when the CPU strobe ends.
  always_ff @(posedge clk or negedge rst_n or posedge cpu_as_n) begin
    if (!rst_n)        ack_q_n <= 1'b1;
    else if (cpu_as_n) ack_q_n <= 1'b1;
    else if (ack_q_n)  ack_q_n <= !(acc_legacy || acc_local);
  end

  // R3
  ack_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_q_n |-> !cpu_as_n);

endmodule

// File: rtl/bus_ack_conditioner.sv
module bus_ack_conditioner
  import bus_ack_pkg::*;
#(
  parameter int AW = 24,
  parameter logic [AW-1:0] ROM_LO = 24'hFC0000,
  parameter logic [AW-1:0] ROM_HI = 24'hFEFFFF,
  parameter logic [AW-1:0] SND_LO = 24'hFF8800,
  parameter logic [AW-1:0] SND_HI = 24'hFF88FF,
  parameter logic [AW-1:0] IO_LO  = 24'hFF8000,
  parameter logic [AW-1:0] IO_HI  = 24'hFFFFFF,
  parameter int DLY_PLAIN = 0,
  parameter int DLY_IO    = 3,
  parameter int DLY_SND   = 2,
  parameter int DLY_ROM   = 3,
  parameter int GUARD_STD = 1,
  parameter int GUARD_IO  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_as_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          legacy_dtack_n,
  output logic          legacy_as_n,
  output logic          snd_cs_n,
  output logic          cpu_dtack_n
);
  logic    slow_as_n;
  logic    ack_q_n;
  logic    acc_legacy, acc_local;
  region_e region;
  logic    hide_legacy;

  ack_as_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_n(cpu_as_n), .sync_n(slow_as_n));

  ack_range_decode #(.AW(AW), .ROM_LO(ROM_LO), .ROM_HI(ROM_HI), .SND_LO(SND_LO),
                     .SND_HI(SND_HI), .IO_LO(IO_LO), .IO_HI(IO_HI)) u_dec (
    .addr(cpu_addr), .region(region));

  ack_sequencer #(.DLY_PLAIN(DLY_PLAIN), .DLY_IO(DLY_IO), .DLY_SND(DLY_SND),
                  .DLY_ROM(DLY_ROM), .GUARD_STD(GUARD_STD), .GUARD_IO(GUARD_IO)) u_seq (
    .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .slow_as_n(slow_as_n),
    .region(region), .legacy_dtack_n(legacy_dtack_n), .ack_q_n(ack_q_n),
    .acc_legacy(acc_legacy), .acc_local(acc_local));

  assign hide_legacy = (region == RG_SND) || (region == RG_ROM);
  assign legacy_as_n = slow_as_n | hide_legacy;
  assign snd_cs_n    = slow_as_n | (region != RG_SND);
  assign cpu_dtack_n = ack_q_n | slow_as_n;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (cpu_dtack_n && snd_cs_n && legacy_as_n));

  // R7
  snd_hides_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snd_cs_n |-> legacy_as_n);

  // R8
  snd_ack_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_dtack_n) && !snd_cs_n) |-> ($past(!snd_cs_n) && $past(!snd_cs_n, 2)));

  // R4
  legacy_ack_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_dtack_n) && (region == RG_PLAIN || region == RG_IO))
      |-> ($past(!legacy_as_n) && $past(!legacy_dtack_n)));

endmodule

// File: tb/bus_ack_conditioner_tb.sv
module bus_ack_conditioner_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_as_n = 1'b1;
  logic [23:0] cpu_addr = '0;
  logic        legacy_dtack_n;
  logic        legacy_as_n, snd_cs_n, cpu_dtack_n;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  bus_ack_conditioner u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_addr(cpu_addr),
    .legacy_dtack_n(legacy_dtack_n), .legacy_as_n(legacy_as_n),
    .snd_cs_n(snd_cs_n), .cpu_dtack_n(cpu_dtack_n));

  // Legacy chipset model: acknowledges m_L edges after its strobe, and holds
  // the acknowledge for 2 edges after the strobe ends. A new acknowledge needs
  // the previous one released first.
  int m_L = 1;
  int m_cnt, m_hold;
  bit m_rel, m_fresh;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      legacy_dtack_n <= 1'b1; m_cnt <= 0; m_hold <= 0; m_rel <= 0; m_fresh <= 0;
    end else begin
      if (legacy_as_n) m_fresh <= 0;
      if (!legacy_dtack_n) begin
        if (legacy_as_n) m_rel <= 1;
        if (m_rel || legacy_as_n) begin
          if (m_hold == 1) begin legacy_dtack_n <= 1'b1; m_hold <= 0; m_rel <= 0; end
          else m_hold <= m_hold + 1;
        end
      end else if (!legacy_as_n) begin
        if (m_cnt + 1 >= m_L) begin legacy_dtack_n <= 1'b0; m_fresh <= 1; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end else m_cnt <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One CPU cycle. exp_lat < 0 skips the latency check; legacy: plain/I/O path.
  task automatic run_cycle(input logic [23:0] a, input int L, input int exp_lat,
                           input bit exp_cs, input bit exp_las, input bit legacy,
                           input int idle, input string req);
    int n, cs_at, las_at;
    bit prev_cs, prev_las;
    @(negedge clk); #1;
    cpu_addr = a; m_L = L; cpu_as_n = 1'b0;
    prev_cs = snd_cs_n; prev_las = legacy_as_n; cs_at = -1; las_at = -1; n = 0;
    while (n < 60) begin
      @(negedge clk); n++;
      if (prev_cs && !snd_cs_n) cs_at = n;
      if (prev_las && !legacy_as_n) las_at = n;
      prev_cs = snd_cs_n; prev_las = legacy_as_n;
      if (!cpu_dtack_n) break;
    end
    chk(n < 60, {req, " ack arrives"}, n, 60);
    if (exp_lat >= 0) chk(n == exp_lat, {req, " ack latency"}, n, exp_lat);
    if (exp_lat >= 0 && exp_las) chk(las_at == 2, "R2 legacy strobe latency", las_at, 2);
    chk(!snd_cs_n == exp_cs, {req, " R7 sound select"}, int'(!snd_cs_n), int'(exp_cs));
    chk(!legacy_as_n == exp_las, {req, " R9 legacy strobe"}, int'(!legacy_as_n), int'(exp_las));
    if (legacy) chk(m_fresh, {req, " R4 ack from current access"}, int'(m_fresh), 1);
    if (exp_cs) chk(n - cs_at == 2, {req, " R8 select to ack"}, n - cs_at, 2);
    #1 cpu_as_n = 1'b1;
    #1 chk(cpu_dtack_n == 1'b1, "R3 async release", int'(cpu_dtack_n), 1);
    repeat (idle) @(negedge clk);
  endtask

  typedef struct packed {
    logic [23:0] addr;
    logic [7:0]  lat_l;
    logic [7:0]  lat;
    logic        cs;
    logic        las;
  } vec_t;

  // Isolated cycles: latency = 3+L plain, max(3+L,5) I/O, 4 sound, 5 ROM.
  localparam vec_t TBL [11] = '{
    '{24'h000400, 8'd1, 8'd4, 1'b0, 1'b1},
    '{24'h001000, 8'd3, 8'd6, 1'b0, 1'b1},
    '{24'hFF8200, 8'd1, 8'd5, 1'b0, 1'b1},
    '{24'hFF8A00, 8'd4, 8'd7, 1'b0, 1'b1},
    '{24'hFF8800, 8'd1, 8'd4, 1'b1, 1'b0},
    '{24'hFF88FE, 8'd1, 8'd4, 1'b1, 1'b0},
    '{24'hFC0000, 8'd1, 8'd5, 1'b0, 1'b0},
    '{24'hFEFFFE, 8'd1, 8'd5, 1'b0, 1'b0},
    '{24'hFBFFFE, 8'd2, 8'd5, 1'b0, 1'b1},
    '{24'hFF87FE, 8'd2, 8'd5, 1'b0, 1'b1},
    '{24'hFF8900, 8'd1, 8'd5, 1'b0, 1'b1}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cpu_dtack_n && snd_cs_n && legacy_as_n, "R1 reset idle", 0, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cpu_dtack_n && snd_cs_n && legacy_as_n, "R1 idle after reset", 0, 1);

    // Table walk; R6 I/O delay, R9 ROM, R11 window priority
    foreach (TBL[i]) begin
      run_cycle(TBL[i].addr, int'(TBL[i].lat_l), int'(TBL[i].lat), TBL[i].cs, TBL[i].las,
                TBL[i].las, 14, "R11 R6 R9 vector");
    end

    // R10 four back-to-back sound writes
    for (int k = 0; k < 4; k++) run_cycle(24'hFF8802, 1, -1, 1'b1, 1'b0, 1'b0, 0, "R10");
    repeat (14) @(negedge clk);

    // R5 back-to-back plain cycles against a lingering legacy acknowledge
    for (int k = 0; k < 4; k++) run_cycle(24'h002000, 1, -1, 1'b0, 1'b1, 1'b1, 0, "R5 plain");
    repeat (14) @(negedge clk);

    // R5 back-to-back I/O cycles with the longer gap
    for (int k = 0; k < 3; k++) run_cycle(24'hFF8400, 4, -1, 1'b0, 1'b1, 1'b1, 0, "R5 io");
    repeat (14) @(negedge clk);

    // R3 strobe withdrawn before any acknowledge: nothing may be seen
    @(negedge clk); #1 cpu_addr = 24'hFC0002; cpu_as_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 cpu_as_n = 1'b1;
    #1 chk(cpu_dtack_n == 1'b1, "R3 aborted cycle", int'(cpu_dtack_n), 1);
    repeat (6) @(negedge clk);
    chk(cpu_dtack_n == 1'b1, "R3 no late ack", int'(cpu_dtack_n), 1);

    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!ended) begin
      ended = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule